// File: doc/BRIEF.md
# Multi-Lane Converter Link Transmitter

This block drives the transmit side of a serial link toward a data converter. It carries up to `LANES` lanes, each moving two octets per clock. A three-state controller runs the link. It first sends comma characters while the receiver requests synchronization. It then sends a lane alignment sequence lasting a programmable number of multiframes. Finally it forwards user octets, either unchanged or scrambled. In data mode the block marks frame ends and multiframe ends by substituting control characters when the data allows it. The receiver uses those characters to monitor alignment.

User logic reads the octet and frame counters to learn where each octet it supplies falls in the frame. On the user side the upper byte of a lane word is the first octet. Each lane leaves the block as 16 data bits and 2 control flags toward an 8b/10b encoder, which expects the first octet in the lower byte. All outputs are registered. Each output word reflects the state, counters and user data of the cycle before.

Top module: `jtx_link_tx`

## Requirements
- R1: `link_state` uses 00 = synchronizing, 01 = alignment sequence, 10 = data; 11 never appears. After reset the state is 00. In state 00 every output octet is 0xBC with its control flag set.
- R2: While `sync_n` is low, the next state is 00, whatever the current state. On that return the counters restart: first-octet index 0, second-octet index 1, both frame counters `K_FR`-1.
- R3: When `sync_n` is high in state 00, the next state is 01. The alignment sequence lasts max(`ila_mf`,3)+1 multiframes, that is that number times `F_OCT`*`K_FR`/2 cycles. It is followed by state 10 with the counters back at the multiframe start.
- R4: `oct_hi` and `oct_lo` give the frame octet index (0 to `F_OCT`-1, counting up) of the first and second octet of the cycle. `frm_hi` and `frm_lo` give their frame index, counting down from `K_FR`-1 to 0. Positions advance by two octets per cycle.
- R5: During the alignment sequence, the first octet of every multiframe is 0x1C with its control flag set. The last octet is 0x7C with its control flag set.
- R6: In the second alignment multiframe, multiframe octet 1 is 0x9C with its control flag set. Octets 2 to 6 carry, in this order: lane number, `LANES`-1, `F_OCT`-1, `K_FR`-1, and the 8-bit sum of those four. Every other alignment octet is the low 8 bits of its position in the multiframe, with no control flag.
- R7: Per lane, output bits [7:0] and control bit 0 carry the first octet (input bits [15:8]). Output bits [15:8] and control bit 1 carry the second octet.
- R8: In state 10 with `scr_en` low, each user octet appears unchanged one cycle later with no control flag, except where R9 substitutes it.
- R9: With `scr_en` low, a frame-end octet that equals the last octet of the previous frame is replaced. It becomes 0x7C when its frame index is 0 and 0xFC otherwise, with the control flag set. The first frame after entering state 10 is never replaced.
- R10: With `scr_en` high, octets are scrambled by 1 + x^14 + x^15. Bits are taken most significant first and the first octet is processed first. The scrambler state is zero on entry to state 10. A frame-end scrambled octet equal to 0xFC (frame index not 0) or 0x7C (frame index 0) gets its control flag set. No other octet gets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sync_n | input | 1 | Active-low synchronization request from the receiver |
| ila_mf | input | 8 | Alignment sequence length selector |
| scr_en | input | 1 | Scrambling enable |
| tx_din | input | LANES*16 | User octets, first octet in the upper byte of each lane |
| tx_dout | output | LANES*16 | Octets to the encoder, first octet in the lower byte of each lane |
| tx_kout | output | LANES*2 | Control-character flags, one per output octet |
| link_state | output | 2 | Controller state |
| oct_hi | output | $clog2(F_OCT) | Frame octet index of the first octet |
| oct_lo | output | $clog2(F_OCT) | Frame octet index of the second octet |
| frm_hi | output | $clog2(K_FR) | Frame index of the first octet |
| frm_lo | output | $clog2(K_FR) | Frame index of the second octet |

## Verification
Two events can fall in the same cycle: the end of the last alignment multiframe, which would move the controller into data mode, and a synchronization request. The bench provokes this by lowering `sync_n` in exactly the cycle whose second octet is the final 0x7C of the sequence. It expects that cycle's output to still show the closing 0x7C, and the next state to be 00 rather than 10. A second collision, between the scrambler and character substitution at a multiframe end, is provoked by choosing inputs whose scrambled value is 0x7C at frame index 0.

// File: rtl/jtx_pkg.sv
package jtx_pkg;

    typedef enum logic [1:0] {
        ST_SYNC = 2'b00,
        ST_ILA  = 2'b01,
        ST_DATA = 2'b10
    } tx_state_e;

    localparam logic [7:0] CH_COMMA = 8'hBC;
    localparam logic [7:0] CH_MFSTART = 8'h1C;
    localparam logic [7:0] CH_MFEND = 8'h7C;
    localparam logic [7:0] CH_CFGMARK = 8'h9C;
    localparam logic [7:0] CH_FREND = 8'hFC;

    // Self-synchronizing scrambler over one 16-bit word, bit 15 first.
    // Returns {next_state[14:0], scrambled[15:0]}.
    function automatic logic [30:0] scr16(input logic [14:0] st, input logic [15:0] d);
        logic [14:0] s;
        logic [15:0] o;
        logic b;
        s = st;
        o = '0;
        for (int i = 15; i >= 0; i--) begin
            b = d[i] ^ s[13] ^ s[14];
            o[i] = b;
            s = {s[13:0], b};
        end
        return {s, o};
    endfunction

endpackage

// File: rtl/jtx_seq.sv
module jtx_seq
    import jtx_pkg::*;
#(
    parameter int F_OCT = 3,
    parameter int K_FR  = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sync_n,
    input  logic [7:0]                 ila_mf,
    output tx_state_e                  state_o,
    output logic [$clog2(F_OCT*K_FR)-1:0] pos_hi_o,
    output logic [$clog2(F_OCT*K_FR)-1:0] pos_lo_o,
    output logic                       second_mf_o,
    output logic [$clog2(F_OCT)-1:0]   oct_hi_o,
    output logic [$clog2(F_OCT)-1:0]   oct_lo_o,
    output logic [$clog2(K_FR)-1:0]    frm_hi_o,
    output logic [$clog2(K_FR)-1:0]    frm_lo_o
);
    localparam int MF = F_OCT * K_FR;
    localparam int PW = $clog2(MF);
    localparam int OW = $clog2(F_OCT);
    localparam int FW = $clog2(K_FR);

    typedef struct packed {
        tx_state_e       st;
        logic [PW-1:0]   pos;
        logic [8:0]      mfc;
        logic [OW-1:0]   oh;
        logic [OW-1:0]   ol;
        logic [FW-1:0]   fh;
        logic [FW-1:0]   fl;
    } seq_t;

    localparam seq_t START = '{st: ST_SYNC, pos: '0, mfc: '0, oh: OW'(0), ol: OW'(1),
                               fh: FW'(K_FR-1), fl: FW'(K_FR-1)};

    seq_t q, n;

    function automatic logic [OW+FW-1:0] adv1(input logic [OW-1:0] o, input logic [FW-1:0] f);
        if (o == OW'(F_OCT-1))
            return {OW'(0), (f == '0) ? FW'(K_FR-1) : f - FW'(1)};
        return {o + OW'(1), f};
    endfunction

    logic [OW+FW-1:0] hi1, hi2, lo2;
    logic [8:0]       last_mf;
    logic [PW-1:0]    pos_lo;

    assign pos_lo  = (q.pos == PW'(MF-1)) ? '0 : q.pos + PW'(1);
    assign last_mf = (ila_mf < 8'd3) ? 9'd3 : {1'b0, ila_mf};

    always_comb begin
        n   = q;
        hi1 = adv1(q.oh, q.fh);
        hi2 = adv1(hi1[OW+FW-1:FW], hi1[FW-1:0]);
        lo2 = adv1(hi2[OW+FW-1:FW], hi2[FW-1:0]);
        if (q.st != ST_SYNC) begin
            n.pos = (q.pos == PW'(MF-2)) ? '0 : q.pos + PW'(2);
            {n.oh, n.fh} = hi2;
            {n.ol, n.fl} = lo2;
        end
        case (q.st)
            ST_SYNC: if (sync_n) n.st = ST_ILA;
            ST_ILA: begin
                if (pos_lo == PW'(MF-1)) begin
                    if (q.mfc == last_mf) begin
                        n.st  = ST_DATA;
                        n.mfc = '0;
                    end else begin
                        n.mfc = q.mfc + 9'd1;
                    end
                end
            end
            ST_DATA: ;
            default: n = START;
        endcase
        if (!sync_n) n = START;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= START;
        else        q <= n;
    end

    assign state_o     = q.st;
    assign pos_hi_o    = q.pos;
    assign pos_lo_o    = pos_lo;
    assign second_mf_o = (q.st == ST_ILA) && (q.mfc == 9'd1);
    assign oct_hi_o    = q.oh;
    assign oct_lo_o    = q.ol;
    assign frm_hi_o    = q.fh;
    assign frm_lo_o    = q.fl;

    a_r1_legal_state: assert property (@(posedge clk) disable iff (!rst_n)
        state_o != 2'b11);
    a_r2_sync_forces: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_n |=> (state_o == ST_SYNC && oct_hi_o == '0 && frm_hi_o == FW'(K_FR-1)));
    a_r3_leave_sync: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_SYNC && sync_n) |=> state_o == ST_ILA);
    a_r3_data_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_DATA && $past(state_o) == ST_ILA) |-> pos_hi_o == '0);
    a_r4_oct_range: assert property (@(posedge clk) disable iff (!rst_n)
        (oct_hi_o <= OW'(F_OCT-1)) && (oct_lo_o <= OW'(F_OCT-1)));

endmodule

// File: rtl/jtx_lane.sv
module jtx_lane
    import jtx_pkg::*;
#(
    parameter int LANE_ID = 0,
    parameter int LANES   = 2,
    parameter int F_OCT   = 3,
    parameter int K_FR    = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  tx_state_e                     state_i,
    input  logic [$clog2(F_OCT*K_FR)-1:0] pos_hi_i,
    input  logic [$clog2(F_OCT*K_FR)-1:0] pos_lo_i,
    input  logic                          second_mf_i,
    input  logic [$clog2(F_OCT)-1:0]      oct_hi_i,
    input  logic [$clog2(F_OCT)-1:0]      oct_lo_i,
    input  logic [$clog2(K_FR)-1:0]       frm_hi_i,
    input  logic [$clog2(K_FR)-1:0]       frm_lo_i,
    input  logic                          scr_en_i,
    input  logic [15:0]                   din_i,
    output logic [15:0]                   dout_o,
    output logic [1:0]                    kout_o
);
    localparam int MF = F_OCT * K_FR;
    localparam int PW = $clog2(MF);
    localparam int OW = $clog2(F_OCT);
    localparam logic [7:0] CSUM = 8'((LANE_ID + LANES - 1 + F_OCT - 1 + K_FR - 1) % 256);

    typedef struct packed {
        logic [14:0] scr;
        logic [7:0]  prev;
        logic        pv;
        logic [15:0] dout;
        logic [1:0]  kout;
    } lane_t;

    lane_t q, n;

    function automatic logic [7:0] cfg_oct(input logic [PW-1:0] idx);
        case (idx)
            PW'(0):  return 8'(LANE_ID);
            PW'(1):  return 8'(LANES - 1);
            PW'(2):  return 8'(F_OCT - 1);
            PW'(3):  return 8'(K_FR - 1);
            default: return CSUM;
        endcase
    endfunction

    function automatic logic [8:0] ila_oct(input logic [PW-1:0] pos, input logic second);
        if (pos == '0)                                return {1'b1, CH_MFSTART};
        if (pos == PW'(MF-1))                         return {1'b1, CH_MFEND};
        if (second && pos == PW'(1))                  return {1'b1, CH_CFGMARK};
        if (second && pos >= PW'(2) && pos <= PW'(6)) return {1'b0, cfg_oct(pos - PW'(2))};
        return {1'b0, 8'(pos)};
    endfunction

    logic [14:0] scr_nx;
    logic [15:0] scr_out;
    logic        fe_h, fe_l, me_h, me_l, ch_h, ch_l, pv1;
    logic [7:0]  vh, vl, pr1;
    logic [8:0]  ih, il;

    always_comb begin
        n = q;
        {scr_nx, scr_out} = scr16(q.scr, din_i);
        fe_h = (oct_hi_i == OW'(F_OCT-1));
        fe_l = (oct_lo_i == OW'(F_OCT-1));
        me_h = fe_h && (frm_hi_i == '0);
        me_l = fe_l && (frm_lo_i == '0);
        ih   = ila_oct(pos_hi_i, second_mf_i);
        il   = ila_oct(pos_lo_i, second_mf_i);
        ch_h = 1'b0;
        ch_l = 1'b0;
        vh   = din_i[15:8];
        vl   = din_i[7:0];
        pv1  = q.pv | fe_h;
        pr1  = fe_h ? din_i[15:8] : q.prev;
        if (scr_en_i) begin
            ch_h = fe_h && (me_h ? scr_out[15:8] == CH_MFEND : scr_out[15:8] == CH_FREND);
            ch_l = fe_l && (me_l ? scr_out[7:0] == CH_MFEND : scr_out[7:0] == CH_FREND);
            vh   = scr_out[15:8];
            vl   = scr_out[7:0];
        end else begin
            ch_h = fe_h && q.pv && (din_i[15:8] == q.prev);
            ch_l = fe_l && pv1 && (din_i[7:0] == pr1);
            if (ch_h) vh = me_h ? CH_MFEND : CH_FREND;
            if (ch_l) vl = me_l ? CH_MFEND : CH_FREND;
        end
        case (state_i)
            ST_ILA: begin
                n.dout = {il[7:0], ih[7:0]};
                n.kout = {il[8], ih[8]};
                n.scr  = '0;
                n.pv   = 1'b0;
            end
            ST_DATA: begin
                n.dout = {vl, vh};
                n.kout = {ch_l, ch_h};
                n.scr  = scr_nx;
                n.pv   = pv1 | fe_l;
                n.prev = fe_l ? din_i[7:0] : pr1;
            end
            default: begin
                n.dout = {CH_COMMA, CH_COMMA};
                n.kout = 2'b11;
                n.scr  = '0;
                n.pv   = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{scr: '0, prev: '0, pv: 1'b0, dout: {CH_COMMA, CH_COMMA}, kout: 2'b11};
        else        q <= n;
    end

    assign dout_o = q.dout;
    assign kout_o = q.kout;

    a_r1_comma_fill: assert property (@(posedge clk) disable iff (!rst_n)
        state_i == ST_SYNC |=> (dout_o == {CH_COMMA, CH_COMMA} && kout_o == 2'b11));
    a_r5_mf_start: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_ILA && pos_hi_i == '0) |=> (dout_o[7:0] == CH_MFSTART && kout_o[0]));
    a_r5_mf_end: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_ILA && pos_lo_i == PW'(MF-1)) |=> (dout_o[15:8] == CH_MFEND && kout_o[1]));
    a_r9_first_flag_only_at_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_DATA && oct_hi_i != OW'(F_OCT-1)) |=> !kout_o[0]);
    a_r10_second_flag_only_at_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_DATA && oct_lo_i != OW'(F_OCT-1)) |=> !kout_o[1]);

endmodule

// File: rtl/jtx_link_tx.sv
module jtx_link_tx
    import jtx_pkg::*;
#(
    parameter int LANES = 2,
    parameter int F_OCT = 3,
    parameter int K_FR  = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sync_n,
    input  logic [7:0]                 ila_mf,
    input  logic                       scr_en,
    input  logic [LANES*16-1:0]        tx_din,
    output logic [LANES*16-1:0]        tx_dout,
    output logic [LANES*2-1:0]         tx_kout,
    output logic [1:0]                 link_state,
    output logic [$clog2(F_OCT)-1:0]   oct_hi,
    output logic [$clog2(F_OCT)-1:0]   oct_lo,
    output logic [$clog2(K_FR)-1:0]    frm_hi,
    output logic [$clog2(K_FR)-1:0]    frm_lo
);
    localparam int PW = $clog2(F_OCT * K_FR);

    tx_state_e     st;
    logic [PW-1:0] pos_hi, pos_lo;
    logic          second_mf;

    jtx_seq #(.F_OCT(F_OCT), .K_FR(K_FR)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .sync_n      (sync_n),
        .ila_mf      (ila_mf),
        .state_o     (st),
        .pos_hi_o    (pos_hi),
        .pos_lo_o    (pos_lo),
        .second_mf_o (second_mf),
        .oct_hi_o    (oct_hi),
        .oct_lo_o    (oct_lo),
        .frm_hi_o    (frm_hi),
        .frm_lo_o    (frm_lo)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        jtx_lane #(.LANE_ID(g), .LANES(LANES), .F_OCT(F_OCT), .K_FR(K_FR)) u_lane (
            .clk         (clk),
            .rst_n       (rst_n),
            .state_i     (st),
            .pos_hi_i    (pos_hi),
            .pos_lo_i    (pos_lo),
            .second_mf_i (second_mf),
            .oct_hi_i    (oct_hi),
            .oct_lo_i    (oct_lo),
            .frm_hi_i    (frm_hi),
            .frm_lo_i    (frm_lo),
            .scr_en_i    (scr_en),
            .din_i       (tx_din[g*16 +: 16]),
            .dout_o      (tx_dout[g*16 +: 16]),
            .kout_o      (tx_kout[g*2 +: 2])
        );
    end

    assign link_state = st;

endmodule

// File: tb/sim_jtx_link_tx.sv
module sim_jtx_link_tx;
    localparam int L  = 2;
    localparam int F  = 3;
    localparam int K  = 4;
    localparam int MF = F * K;

    logic            clk = 1'b0;
    logic            rst_n, sync_n, scr_en;
    logic [7:0]      ila_mf;
    logic [L*16-1:0] tx_din, tx_dout;
    logic [L*2-1:0]  tx_kout;
    logic [1:0]      link_state, oct_hi, oct_lo, frm_hi, frm_lo;

    always #2ns clk = ~clk;

    jtx_link_tx #(.LANES(L), .F_OCT(F), .K_FR(K)) u0 (
        .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .ila_mf(ila_mf), .scr_en(scr_en),
        .tx_din(tx_din), .tx_dout(tx_dout), .tx_kout(tx_kout), .link_state(link_state),
        .oct_hi(oct_hi), .oct_lo(oct_lo), .frm_hi(frm_hi), .frm_lo(frm_lo)
    );

    typedef struct {
        logic [L*16-1:0] d;
        logic [L*2-1:0]  k;
        string           tag;
    } exp_t;
    exp_t sb[$];

    int checks = 0, errors = 0;
    bit done = 1'b0;

    // independent model
    int          m_state, m_mpos, m_mfc;
    logic [14:0] m_scr[L];
    logic [7:0]  m_prev[L];
    bit          m_pv[L];
    int          fmode;
    int          ila_run, ila_exp, port_prev;

    task automatic check(string tag, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic scr_oct(inout logic [14:0] st, input logic [7:0] v, input bit inv,
                           output logic [7:0] d, output logic [7:0] s);
        logic fb;
        for (int i = 7; i >= 0; i--) begin
            fb = st[13] ^ st[14];
            if (inv) begin s[i] = v[i]; d[i] = v[i] ^ fb; end
            else     begin d[i] = v[i]; s[i] = v[i] ^ fb; end
            st = {st[13:0], s[i]};
        end
    endtask

    function automatic logic [8:0] ila_val(int lane, int pos, int mfc);
        logic [7:0] cs;
        cs = 8'((lane + (L-1) + (F-1) + (K-1)) % 256);
        if (pos == 0)      return {1'b1, 8'h1C};
        if (pos == MF-1)   return {1'b1, 8'h7C};
        if (mfc == 1 && pos == 1) return {1'b1, 8'h9C};
        if (mfc == 1 && pos == 2) return {1'b0, 8'(lane)};
        if (mfc == 1 && pos == 3) return {1'b0, 8'(L-1)};
        if (mfc == 1 && pos == 4) return {1'b0, 8'(F-1)};
        if (mfc == 1 && pos == 5) return {1'b0, 8'(K-1)};
        if (mfc == 1 && pos == 6) return {1'b0, cs};
        return {1'b0, 8'(pos)};
    endfunction

    function automatic int mf_last();
        return (ila_mf < 3) ? 3 : int'(ila_mf);
    endfunction

    // driver: checks ports against model, drives data, pushes expectation, advances model
    task automatic step();
        exp_t e;
        logic [7:0] v, d, s;
        bit   kf, fe, me;
        int   pos;
        // state duration (R3) seen at the ports
        if (link_state == 2'b01) ila_run++;
        else begin
            if (port_prev == 1 && link_state == 2'b10)
                check("R3", "alignment cycles", ila_run, ila_exp);
            ila_run = 0;
        end
        port_prev = int'(link_state);
        check("R1 R2 R3", "state", link_state, m_state);
        check("R4", "oct_hi", oct_hi, m_mpos % F);
        check("R4", "oct_lo", oct_lo, ((m_mpos + 1) % MF) % F);
        check("R4", "frm_hi", frm_hi, K - 1 - m_mpos / F);
        check("R4", "frm_lo", frm_lo, K - 1 - ((m_mpos + 1) % MF) / F);
        e.tag = (m_state == 0) ? "R1" : (m_state == 1) ? "R5 R6 R7" :
                (scr_en ? "R10 R7" : "R7 R8 R9");
        for (int ln = 0; ln < L; ln++) begin
            for (int j = 0; j < 2; j++) begin
                pos = (m_mpos + j) % MF;
                fe  = (pos % F) == F - 1;
                me  = pos == MF - 1;
                d   = 8'($urandom);
                if (m_state == 0) begin
                    v = 8'hBC; kf = 1'b1;
                end else if (m_state == 1) begin
                    {kf, v} = ila_val(ln, pos, m_mfc);
                end else if (scr_en) begin
                    if (fmode == 1 && fe) scr_oct(m_scr[ln], me ? 8'h7C : 8'hFC, 1'b1, d, s);
                    else                  scr_oct(m_scr[ln], d, 1'b0, d, s);
                    kf = fe && (me ? s == 8'h7C : s == 8'hFC);
                    v  = s;
                    if (fe) begin m_prev[ln] = d; m_pv[ln] = 1'b1; end
                end else begin
                    if (fmode == 1 && fe && m_pv[ln]) d = m_prev[ln];
                    kf = fe && m_pv[ln] && d == m_prev[ln];
                    v  = kf ? (me ? 8'h7C : 8'hFC) : d;
                    if (fe) begin m_prev[ln] = d; m_pv[ln] = 1'b1; end
                end
                tx_din[ln*16 + 8 - 8*j +: 8] = d;
                e.d[ln*16 + 8*j +: 8] = v;
                e.k[ln*2 + j] = kf;
            end
            if (m_state != 2) begin m_scr[ln] = '0; m_pv[ln] = 1'b0; end
        end
        sb.push_back(e);
        // next model state
        if (!sync_n) begin
            m_state = 0; m_mpos = 0; m_mfc = 0;
        end else if (m_state == 0) begin
            m_state = 1;
            ila_exp = (mf_last() + 1) * MF / 2;
        end else begin
            if (m_state == 1 && m_mpos + 1 == MF - 1) begin
                if (m_mfc == mf_last()) begin m_state = 2; m_mfc = 0; end
                else m_mfc++;
            end
            m_mpos = (m_mpos + 2) % MF;
        end
        @(negedge clk);
    endtask

    // monitor: compares registered outputs just after each rising edge
    always @(posedge clk) begin
        #1ns;
        if (rst_n && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (tx_dout !== e.d || tx_kout !== e.k) begin
                errors++;
                $display("FAIL %s data: actual %h/%b expected %h/%b", e.tag, tx_dout, tx_kout, e.d, e.k);
            end
        end
    end

    initial begin
        #800000ns;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bit hit;
        rst_n = 1'b0; sync_n = 1'b0; scr_en = 1'b0; ila_mf = 8'd3; tx_din = '0;
        fmode = 0; ila_run = 0; ila_exp = 0; port_prev = 0;
        m_state = 0; m_mpos = 0; m_mfc = 0;
        for (int ln = 0; ln < L; ln++) begin m_scr[ln] = '0; m_prev[ln] = '0; m_pv[ln] = 1'b0; end
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "reset state", link_state, 0);
        check("R1", "reset data", tx_dout, {L{16'hBCBC}});
        check("R1", "reset flags", tx_kout, {L*2{1'b1}});
        rst_n = 1'b1;
        repeat (4) step();
        // alignment of 4 multiframes, then unscrambled data
        sync_n = 1'b1;
        repeat (24 + 30) step();
        fmode = 1;                          // R9 forced repeats at frame ends
        repeat (30) step();
        // R2: sync request in data mode
        sync_n = 1'b0;
        repeat (3) step();
        // R3 clamp (0 -> 4 multiframes), R10 scrambling
        sync_n = 1'b1; ila_mf = 8'd0; scr_en = 1'b1; fmode = 0;
        repeat (24 + 20) step();
        fmode = 1;
        repeat (30) step();
        // collision: sync request in the final alignment cycle
        sync_n = 1'b0; step();
        sync_n = 1'b1; ila_mf = 8'd5; scr_en = 1'b0; fmode = 0;
        hit = 1'b0;
        for (int i = 0; i < 300 && !hit; i++) begin
            if (m_state == 1 && m_mfc == 5 && m_mpos == MF - 2) begin
                sync_n = 1'b0;
                hit = 1'b1;
            end
            step();
        end
        check("R2", "collision reached", hit, 1);
        check("R2", "state after collision", link_state, 0);
        sync_n = 1'b1; ila_mf = 8'd3;
        repeat (24 + 12) step();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule